// File: doc/BRIEF.md
# Fractional-Rate Master Time Counter

This block keeps a 64-bit time count that advances at a fixed nominal rate of 6.144 MHz. The system clock that drives it runs faster than that rate, and its frequency may change between operating modes. Two small programmable values, a numerator and a denominator, set the count rate. On every system clock a fractional accumulator adds the numerator. Whenever the sum reaches the denominator, the count steps by one and the denominator is taken off the sum. The count rate is therefore the clock rate multiplied by numerator over denominator. When the clock changes, software writes a new pair so that the rate stays the same.

A slow reference tick from a 32 kHz-class source corrects the fine count. The tick must already be synchronous to the system clock and one cycle wide. On every tick the count is set to the number of ticks seen since reset, multiplied by the parameter giving the expected fine counts per tick. The accumulator is cleared at the same time. If the reference runs fast or slow, the count rate moves by the same ratio.

Software reaches the two rate registers and both halves of the count through a simple register port. Reading the low half of the count captures the high half, so a low-then-high read pair is coherent.

Top module: `rt_master_counter`

## Requirements
- R1: After reset the count is 0, and both rate registers read 0.
- R2: Each clock adds the effective numerator to the accumulator. When the sum is at least the denominator, the count steps by exactly one and the denominator is subtracted. Over N clocks that start from a cleared accumulator, the count advances by floor(N*num/den), so equal ratios such as 3/8 and 6/16 give equal rates.
- R3: A numerator larger than the denominator is treated as equal to it, so the count steps at most once per clock.
- R4: While the denominator is 0, the count holds and the accumulator stays 0.
- R5: The numerator register is at byte offset 0x10 and the denominator register is at 0x14. Bits [11:0] of each give the value used. Bits [31:12] are stored and read back unchanged.
- R6: A write to the denominator register clears the accumulator at that clock edge and suppresses the step on that edge.
- R7: A slow tick sets the count, from the next edge, to (ticks since reset) * TICK_STEP modulo 2^64 and clears the accumulator.
- R8: The count wraps from 2^64-1 to 0.
- R9: Offset 0x00 reads count bits [31:0]. Offset 0x04 reads the high half that was captured on the last clock where a read strobe addressed offset 0x00.
- R10: `count_o` shows the count register directly, with no added delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (captures the high half when it addresses 0x00) |
| reg_addr_i | input | ADDR_W | Byte offset of the register |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Read data, combinational from the address |
| slow_tick_i | input | 1 | One-cycle correction pulse from the slow reference |
| count_o | output | 2*DATA_W | Current count |

## Verification
A wrong accumulator phase does not show at once. It appears as a count that is one step early or late, within one denominator period after a clear, so the bench measures increments over short windows that start right after a clear. A fault in the tick-target register shows on `count_o` on the first clock after the next tick. A stale or mistimed high-half capture shows only when the count carries across the low-word boundary between the two reads, so the bench places the count a few steps below a carry before it reads.

// File: rtl/mctr_pkg.sv
package mctr_pkg;

    // Byte offsets of the register port
    localparam int unsigned OFS_CNT_LO = 32'h00;
    localparam int unsigned OFS_CNT_HI = 32'h04;
    localparam int unsigned OFS_NUM    = 32'h10;
    localparam int unsigned OFS_DEN    = 32'h14;

endpackage

// File: rtl/mctr_frac.sv
module mctr_frac #(
    parameter int unsigned FRAC_W = 12
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [FRAC_W-1:0] num_i,
    input  logic [FRAC_W-1:0] den_i,
    input  logic              clear_i,
    output logic              step_o
);
    localparam int unsigned SUM_W = FRAC_W + 1;

    typedef struct packed {
        logic [FRAC_W-1:0] acc;
    } frac_st_t;

    frac_st_t st_d, st_q;
    logic [FRAC_W-1:0] acc_q;
    logic [FRAC_W-1:0] num_eff;
    logic [SUM_W-1:0]  sum;
    logic [SUM_W-1:0]  den_ext;

    assign acc_q = st_q.acc;

    always_comb begin
        num_eff = (num_i > den_i) ? den_i : num_i;
        den_ext = {1'b0, den_i};
        sum     = {1'b0, acc_q} + {1'b0, num_eff};
        st_d    = st_q;
        step_o  = 1'b0;
        if (clear_i || (den_i == '0)) begin
            st_d.acc = '0;
        end else if (sum >= den_ext) begin
            step_o   = 1'b1;
            st_d.acc = FRAC_W'(sum - den_ext);
        end else begin
            st_d.acc = sum[FRAC_W-1:0];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/mctr_count.sv
module mctr_count #(
    parameter int unsigned             CNT_W     = 64,
    parameter logic [CNT_W-1:0]        TICK_STEP = 188
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             step_i,
    input  logic             tick_i,
    output logic [CNT_W-1:0] count_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] target;
    } cnt_st_t;

    cnt_st_t st_d, st_q;
    logic [CNT_W-1:0] next_target;

    always_comb begin
        next_target = st_q.target + TICK_STEP;
        st_d        = st_q;
        if (tick_i) begin
            st_d.target = next_target;
            st_d.cnt    = next_target;
        end else if (step_i) begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_o = st_q.cnt;

endmodule

// File: rtl/mctr_regs.sv
module mctr_regs
    import mctr_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned FRAC_W = 12
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                wr_i,
    input  logic                rd_i,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic [DATA_W-1:0]   wdata_i,
    input  logic [2*DATA_W-1:0] count_i,
    output logic [DATA_W-1:0]   rdata_o,
    output logic [FRAC_W-1:0]   num_o,
    output logic [FRAC_W-1:0]   den_o,
    output logic                den_wr_o
);
    typedef struct packed {
        logic [DATA_W-1:0] num;
        logic [DATA_W-1:0] den;
        logic [DATA_W-1:0] hi;
    } reg_st_t;

    reg_st_t st_d, st_q;
    logic [DATA_W-1:0] hi_q;
    logic sel_lo, sel_hi, sel_num, sel_den;

    assign hi_q = st_q.hi;

    always_comb begin
        sel_lo  = (addr_i == ADDR_W'(OFS_CNT_LO));
        sel_hi  = (addr_i == ADDR_W'(OFS_CNT_HI));
        sel_num = (addr_i == ADDR_W'(OFS_NUM));
        sel_den = (addr_i == ADDR_W'(OFS_DEN));

        st_d = st_q;
        if (wr_i && sel_num) st_d.num = wdata_i;
        if (wr_i && sel_den) st_d.den = wdata_i;
        if (rd_i && sel_lo)  st_d.hi  = count_i[2*DATA_W-1:DATA_W];

        den_wr_o = wr_i && sel_den;

        if (sel_lo)       rdata_o = count_i[DATA_W-1:0];
        else if (sel_hi)  rdata_o = hi_q;
        else if (sel_num) rdata_o = st_q.num;
        else if (sel_den) rdata_o = st_q.den;
        else              rdata_o = '0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign num_o = st_q.num[FRAC_W-1:0];
    assign den_o = st_q.den[FRAC_W-1:0];

endmodule

// File: rtl/rt_master_counter.sv
module rt_master_counter
    import mctr_pkg::*;
#(
    parameter int unsigned           DATA_W    = 32,
    parameter int unsigned           ADDR_W    = 8,
    parameter int unsigned           FRAC_W    = 12,
    parameter logic [2*DATA_W-1:0]   TICK_STEP = 188
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                reg_wr_i,
    input  logic                reg_rd_i,
    input  logic [ADDR_W-1:0]   reg_addr_i,
    input  logic [DATA_W-1:0]   reg_wdata_i,
    output logic [DATA_W-1:0]   reg_rdata_o,
    input  logic                slow_tick_i,
    output logic [2*DATA_W-1:0] count_o
);
    localparam int unsigned CNT_W = 2 * DATA_W;

    logic [FRAC_W-1:0] num;
    logic [FRAC_W-1:0] den;
    logic              den_wr;
    logic              step;
    logic [CNT_W-1:0]  count;

    mctr_regs #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W),
        .FRAC_W (FRAC_W)
    ) regs_i (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .wr_i     (reg_wr_i),
        .rd_i     (reg_rd_i),
        .addr_i   (reg_addr_i),
        .wdata_i  (reg_wdata_i),
        .count_i  (count),
        .rdata_o  (reg_rdata_o),
        .num_o    (num),
        .den_o    (den),
        .den_wr_o (den_wr)
    );

    mctr_frac #(
        .FRAC_W (FRAC_W)
    ) frac_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .num_i   (num),
        .den_i   (den),
        .clear_i (den_wr | slow_tick_i),
        .step_o  (step)
    );

    mctr_count #(
        .CNT_W     (CNT_W),
        .TICK_STEP (TICK_STEP)
    ) count_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .step_i  (step),
        .tick_i  (slow_tick_i),
        .count_o (count)
    );

    assign count_o = count;

endmodule

// File: rtl/rt_master_counter_chk.sv
module rt_master_counter_chk #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned FRAC_W = 12
) (
    input logic                clk_i,
    input logic                rst_ni,
    input logic                slow_tick_i,
    input logic [FRAC_W-1:0]   den_i,
    input logic [2*DATA_W-1:0] count_i
);
    // R2 / R3: outside a tick the count moves by zero or one
    a_r2_single_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !slow_tick_i |=> (count_i == $past(count_i)) ||
                         (count_i == $past(count_i) + (2*DATA_W)'(1)));

    // R4: zero denominator freezes the count
    a_r4_den_zero_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!slow_tick_i && den_i == '0) |=> $stable(count_i));
endmodule

module mctr_frac_chk #(
    parameter int unsigned FRAC_W = 12
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              clear_i,
    input logic [FRAC_W-1:0] den_i,
    input logic [FRAC_W-1:0] acc_i
);
    // R2: accumulator always stays below a nonzero denominator
    a_r2_acc_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (den_i != '0) |-> (acc_i < den_i));

    // R6 / R7: denominator write or slow tick leaves the accumulator empty
    a_r6_clear_empties_acc: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clear_i |=> (acc_i == '0));
endmodule

module mctr_regs_chk
    import mctr_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 8
) (
    input logic                clk_i,
    input logic                rst_ni,
    input logic                rd_i,
    input logic [ADDR_W-1:0]   addr_i,
    input logic [2*DATA_W-1:0] count_i,
    input logic [DATA_W-1:0]   hi_i
);
    // R9: low-word read captures the high half of that cycle
    a_r9_hi_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_i && addr_i == ADDR_W'(OFS_CNT_LO)) |=>
            (hi_i == $past(count_i[2*DATA_W-1:DATA_W])));

    // R9: without a low-word read the captured half is kept
    a_r9_hi_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(rd_i && addr_i == ADDR_W'(OFS_CNT_LO)) |=> $stable(hi_i));
endmodule

bind rt_master_counter rt_master_counter_chk #(
    .DATA_W (DATA_W),
    .FRAC_W (FRAC_W)
) top_chk_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .slow_tick_i (slow_tick_i),
    .den_i       (den),
    .count_i     (count_o)
);

bind mctr_frac mctr_frac_chk #(
    .FRAC_W (FRAC_W)
) frac_chk_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (clear_i),
    .den_i   (den_i),
    .acc_i   (acc_q)
);

bind mctr_regs mctr_regs_chk #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
) regs_chk_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rd_i    (rd_i),
    .addr_i  (addr_i),
    .count_i (count_i),
    .hi_i    (hi_q)
);

// File: tb/rt_master_counter_tb_top.sv
`timescale 1ns/1ps
module rt_master_counter_tb_top;

    localparam logic [63:0] K = 64'hFFFF_FFFF_FFFF_FFF0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr = 1'b0;
    logic        rd = 1'b0;
    logic [7:0]  addr = 8'h00;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        tick = 1'b0;
    logic [63:0] count;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    rt_master_counter #(
        .DATA_W    (32),
        .ADDR_W    (8),
        .FRAC_W    (12),
        .TICK_STEP (K)
    ) dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .reg_wr_i    (wr),
        .reg_rd_i    (rd),
        .reg_addr_i  (addr),
        .reg_wdata_i (wdata),
        .reg_rdata_o (rdata),
        .slow_tick_i (tick),
        .count_o     (count)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // all tasks start and end at a falling edge
    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
        wr = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic reg_read(input logic [7:0] a, input bit strobe, output logic [31:0] d);
        addr = a; rd = strobe;
        #1 d = rdata;
        if (strobe) begin
            @(posedge clk);
            @(negedge clk);
            rd = 1'b0;
        end
    endtask

    task automatic pulse_tick();
        tick = 1'b1;
        @(posedge clk);
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check("R1 count after reset", count, 64'd0);
        reg_read(8'h10, 1'b0, d);
        check("R1 numerator after reset", {32'd0, d}, 64'd0);
        reg_read(8'h14, 1'b0, d);
        check("R1 denominator after reset", {32'd0, d}, 64'd0);
        wait_cyc(10);
        check("R4 zero denominator holds after reset", count, 64'd0);
    endtask

    task automatic t_rate_and_fields();
        logic [31:0] d;
        logic [63:0] c0;
        reg_write(8'h10, 32'hABCD_E003);
        reg_write(8'h14, 32'hFFFF_F008);
        reg_read(8'h10, 1'b0, d);
        check("R5 numerator upper bits kept", {32'd0, d}, 64'hABCD_E003);
        reg_read(8'h14, 1'b0, d);
        check("R5 denominator upper bits kept", {32'd0, d}, 64'hFFFF_F008);
        c0 = count;
        wait_cyc(80);
        check("R2 ratio 3/8 over 80 clocks", count - c0, 64'd30);
    endtask

    task automatic t_equal_ratio();
        logic [63:0] c0;
        reg_write(8'h10, 32'h0000_0006);
        reg_write(8'h14, 32'h0000_0010);
        c0 = count;
        wait_cyc(80);
        check("R2 ratio 6/16 matches 3/8", count - c0, 64'd30);
    endtask

    task automatic t_den_clear();
        logic [63:0] c0;
        reg_write(8'h10, 32'd3);
        reg_write(8'h14, 32'd8);
        wait_cyc(2);
        c0 = count;
        reg_write(8'h14, 32'd8);
        wait_cyc(2);
        check("R6 denominator write restarts phase", count - c0, 64'd0);
    endtask

    task automatic t_clamp();
        logic [63:0] c0;
        reg_write(8'h10, 32'd10);
        reg_write(8'h14, 32'd4);
        c0 = count;
        wait_cyc(20);
        check("R3 numerator above denominator", count - c0, 64'd20);
    endtask

    task automatic t_low_bits();
        logic [31:0] d;
        logic [63:0] c0;
        reg_write(8'h10, 32'h1234_5005);
        reg_write(8'h14, 32'h0000_000A);
        reg_read(8'h10, 1'b0, d);
        check("R5 numerator readback", {32'd0, d}, 64'h1234_5005);
        c0 = count;
        wait_cyc(20);
        check("R5 only low 12 bits set rate", count - c0, 64'd10);
    endtask

    task automatic t_den_zero();
        logic [63:0] c0;
        reg_write(8'h10, 32'd1);
        reg_write(8'h14, 32'd0);
        c0 = count;
        wait_cyc(10);
        check("R4 zero denominator holds", count, c0);
    endtask

    task automatic t_tick_wrap_read();
        logic [31:0] d;
        reg_write(8'h14, 32'd1);
        pulse_tick();
        check("R7 first tick target", count, K);
        reg_read(8'h00, 1'b1, d);
        check("R9 low word read", {32'd0, d}, {32'd0, K[31:0]});
        wait_cyc(15);
        check("R8 count wraps to zero", count, 64'd0);
        check("R10 count_o is the count", count, 64'd0);
        reg_read(8'h04, 1'b0, d);
        check("R9 high half held from capture", {32'd0, d}, 64'h0000_0000_FFFF_FFFF);
        reg_read(8'h00, 1'b1, d);
        check("R9 low word after wrap", {32'd0, d}, 64'd0);
        reg_read(8'h04, 1'b0, d);
        check("R9 high half recaptured", {32'd0, d}, 64'd0);
        pulse_tick();
        check("R7 second tick target", count, 64'hFFFF_FFFF_FFFF_FFE0);
    endtask

    task automatic t_tick_clears_acc();
        reg_write(8'h10, 32'd3);
        reg_write(8'h14, 32'd8);
        wait_cyc(1);
        pulse_tick();
        check("R7 third tick target", count, 64'hFFFF_FFFF_FFFF_FFD0);
        wait_cyc(1);
        check("R7 tick clears accumulator", count, 64'hFFFF_FFFF_FFFF_FFD0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_rate_and_fields();
        t_equal_ratio();
        t_den_clear();
        t_clamp();
        t_low_bits();
        t_den_zero();
        t_tick_wrap_read();
        t_tick_clears_acc();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(20 * 200000);
        checks++;
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule